// File: doc/BRIEF.md
# Key-Locked Oscillator Configuration Register

This block holds the configuration word for a clock synthesiser and guards it against stray writes. A companion lock register must first be loaded with a 16-bit unlock key. Only while the key is held does the oscillator register accept a write. Software relocks by writing any other value to the lock register, normally zero. The usual sequence is: write the key, update the oscillator word, write zero to the lock register.

The oscillator word carries three fields: a 9-bit VCO divider, a 7-bit reference divider and a 3-bit output select. They are decoded onto dedicated outputs that feed the synthesiser. Bits above the 19 configuration bits are fixed at their reset default and no write changes them, so a read-modify-write by software can never disturb them. Access is through a plain single-cycle register interface. Reads return the addressed register combinationally in the same cycle.

Top module: `osc_cfg_lockreg`

## Requirements
- R1: After synchronous reset the block is locked (`locked_o`=1), the lock register reads 0x0001_0000, and the oscillator word and its decoded fields equal the `OSC_DEFAULT` parameter.
- R2: A write to address 0 (lock register) stores `wr_data_i[15:0]`. The next cycle, `locked_o` is 0 exactly when the stored value equals `UNLOCK_KEY` (default 0xA05F). Reading address 0 returns the locked flag in bit 16, the stored value in bits [15:0], and zero in bits [31:17].
- R3: A write to address 1 (oscillator register) while unlocked loads `wr_data_i[18:0]` at the next edge. The VCO divider output is bits [8:0], the reference divider output is bits [15:9], and the output select is bits [18:16].
- R4: A write to address 1 while locked is ignored, and the oscillator word keeps its contents.
- R5: Bits [31:19] of the oscillator word always read as `OSC_DEFAULT[31:19]`, whatever data is written.
- R6: Only the low 16 bits of a lock write are compared with the key: 0xFFFF_A05F unlocks. Any value whose low 16 bits differ from the key relocks, whether it is zero, non-zero, or the key with a single bit flipped.
- R7: While unlocked, any number of consecutive oscillator writes are all accepted. The block relocks only on a lock-register write.
- R8: Addresses 2 and 3 are unmapped: writes to them change neither register, and reads return zero.
- R9: `rd_data_o` reflects the register selected by `addr_i` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 lock, 1 oscillator) |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i` |
| vco_div_o | output | 9 | VCO divider field |
| ref_div_o | output | 7 | Reference divider field |
| out_sel_o | output | 3 | Output select field |
| locked_o | output | 1 | 1 while oscillator writes are blocked |

## Verification
The hardest case to reach is a lock value that almost matches the key. A register that compares only part of the key would treat such a value as unlocking. The stimulus therefore writes every single-bit flip of the key, plus the key with its upper half set, and attempts an oscillator write after each one to prove that nothing was let through. A sweep of all 512 VCO divider values, paired with arithmetically derived reference and select values and garbage in the upper bits, confirms the field placement and that the fixed bits are preserved.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;
    localparam int VCO_W  = 9;
    localparam int REF_W  = 7;
    localparam int SEL_W  = 3;
    localparam int CFG_W  = VCO_W + REF_W + SEL_W;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_LOCK = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_OSC  = ADDR_W'(1);

    // Packed MSB first: select sits on top, VCO divider in the low bits.
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [REF_W-1:0] rdiv;
        logic [VCO_W-1:0] vdiv;
    } osc_fields_t;

    typedef enum logic [1:0] {
        TGT_LOCK = 2'd0,
        TGT_OSC  = 2'd1,
        TGT_NONE = 2'd2
    } reg_tgt_e;

    function automatic reg_tgt_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == ADDR_LOCK)     return TGT_LOCK;
        else if (a == ADDR_OSC) return TGT_OSC;
        else                    return TGT_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] lock_view(input logic lk,
                                                    input logic [KEY_W-1:0] v);
        return {{(DATA_W-KEY_W-1){1'b0}}, lk, v};
    endfunction
endpackage

// File: rtl/osc_addr_decode.sv
module osc_addr_decode
    import osc_cfg_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output reg_tgt_e          tgt,
    output logic              lock_we,
    output logic              osc_we
);
    always_comb begin
        tgt     = decode_addr(addr);
        lock_we = wr_en && (tgt == TGT_LOCK);
        osc_we  = wr_en && (tgt == TGT_OSC);
    end
endmodule

// File: rtl/osc_key_lock.sv
module osc_key_lock
    import osc_cfg_pkg::*;
#(
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_we,
    input  logic [KEY_W-1:0] key_in,
    output logic [KEY_W-1:0] key_q,
    output logic             locked
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            open_q <= 1'b0;
        end else if (lock_we) begin
            key_q  <= key_in;
            open_q <= (key_in == UNLOCK_KEY);
        end
    end

    assign locked = ~open_q;
endmodule

// File: rtl/osc_word_reg.sv
module osc_word_reg
    import osc_cfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] OSC_DEFAULT = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_we,
    input  logic              locked,
    input  osc_fields_t       cfg_in,
    output osc_fields_t       cfg_q,
    output logic [DATA_W-1:0] word
);
    localparam osc_fields_t CFG_RST = osc_fields_t'(OSC_DEFAULT[CFG_W-1:0]);
    localparam logic [DATA_W-CFG_W-1:0] FIXED_HI = OSC_DEFAULT[DATA_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RST;
        else if (osc_we && !locked)
            cfg_q <= cfg_in;
    end

    assign word = {FIXED_HI, cfg_q};
endmodule

// File: rtl/osc_cfg_lockreg.sv
module osc_cfg_lockreg
    import osc_cfg_pkg::*;
#(
    parameter logic [KEY_W-1:0]  UNLOCK_KEY  = 16'hA05F,
    parameter logic [DATA_W-1:0] OSC_DEFAULT = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [VCO_W-1:0]  vco_div_o,
    output logic [REF_W-1:0]  ref_div_o,
    output logic [SEL_W-1:0]  out_sel_o,
    output logic              locked_o
);
    reg_tgt_e          tgt;
    logic              lock_we, osc_we, locked;
    logic [KEY_W-1:0]  key_q;
    osc_fields_t       cfg_q;
    logic [DATA_W-1:0] osc_word;
    logic              unused_hi;

    assign unused_hi = ^wr_data_i[DATA_W-1:CFG_W];

    osc_addr_decode u_dec (
        .wr_en   (wr_en_i),
        .addr    (addr_i),
        .tgt     (tgt),
        .lock_we (lock_we),
        .osc_we  (osc_we)
    );

    osc_key_lock #(.UNLOCK_KEY(UNLOCK_KEY)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .lock_we (lock_we),
        .key_in  (wr_data_i[KEY_W-1:0]),
        .key_q   (key_q),
        .locked  (locked)
    );

    osc_word_reg #(.OSC_DEFAULT(OSC_DEFAULT)) u_word (
        .clk     (clk),
        .rst     (rst),
        .osc_we  (osc_we),
        .locked  (locked),
        .cfg_in  (osc_fields_t'(wr_data_i[CFG_W-1:0])),
        .cfg_q   (cfg_q),
        .word    (osc_word)
    );

    always_comb begin
        unique case (tgt)
            TGT_LOCK: rd_data_o = lock_view(locked, key_q);
            TGT_OSC:  rd_data_o = osc_word;
            default:  rd_data_o = '0;
        endcase
    end

    assign vco_div_o = cfg_q.vdiv;
    assign ref_div_o = cfg_q.rdiv;
    assign out_sel_o = cfg_q.sel;
    assign locked_o  = locked;
endmodule

// File: rtl/osc_cfg_checker.sv
module osc_cfg_checker
    import osc_cfg_pkg::*;
#(
    parameter logic [KEY_W-1:0]  UNLOCK_KEY  = 16'hA05F,
    parameter logic [DATA_W-1:0] OSC_DEFAULT = 32'h0000_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [VCO_W-1:0]  vco_div_o,
    input logic [REF_W-1:0]  ref_div_o,
    input logic [SEL_W-1:0]  out_sel_o,
    input logic              locked_o
);
    logic [CFG_W-1:0] fields;
    assign fields = {out_sel_o, ref_div_o, vco_div_o};

    assert_reset_locks_R1: assert property (@(posedge clk)
        rst |=> locked_o);

    assert_key_compare_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADDR_LOCK) |=>
            (locked_o == ($past(wr_data_i[KEY_W-1:0]) != UNLOCK_KEY)));

    assert_write_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADDR_OSC && !locked_o) |=>
            (fields == $past(wr_data_i[CFG_W-1:0])));

    assert_locked_ignore_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADDR_OSC && locked_o) |=> $stable(fields));

    assert_fixed_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (addr_i == ADDR_OSC) |-> (rd_data_o[DATA_W-1:CFG_W] == OSC_DEFAULT[DATA_W-1:CFG_W]));

    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && addr_i == ADDR_LOCK) |=> $stable(locked_o));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (addr_i != ADDR_LOCK && addr_i != ADDR_OSC) |-> (rd_data_o == '0));
endmodule

bind osc_cfg_lockreg osc_cfg_checker #(
    .UNLOCK_KEY  (UNLOCK_KEY),
    .OSC_DEFAULT (OSC_DEFAULT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .vco_div_o (vco_div_o),
    .ref_div_o (ref_div_o),
    .out_sel_o (out_sel_o),
    .locked_o  (locked_o)
);

// File: tb/tb_osc_cfg_lockreg.sv
module tb_osc_cfg_lockreg;
    localparam logic [15:0] KEY = 16'hA05F;
    localparam logic [31:0] DEF = 32'hBEE5_3A6C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [8:0]  vco;
    logic [6:0]  rdv;
    logic [2:0]  sel;
    logic        locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [18:0] exp_cfg;

    always #10 clk = ~clk;

    osc_cfg_lockreg #(.UNLOCK_KEY(KEY), .OSC_DEFAULT(DEF)) dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
        .rd_data_o(rdata), .vco_div_o(vco), .ref_div_o(rdv), .out_sel_o(sel),
        .locked_o(locked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic check_cfg(input string req, input logic [18:0] e);
        logic [31:0] v;
        check({req, " vco"}, {23'd0, vco}, {23'd0, e[8:0]});
        check({req, " ref"}, {25'd0, rdv}, {25'd0, e[15:9]});
        check({req, " sel"}, {29'd0, sel}, {29'd0, e[18:16]});
        rd(2'd1, v);
        check({req, " R5 R9 osc read"}, v, {DEF[31:19], e});
    endtask

    task automatic check_lock(input string req, input logic lk, input logic [15:0] k);
        logic [31:0] v;
        check({req, " locked_o"}, {31'd0, locked}, {31'd0, lk});
        rd(2'd0, v);
        check({req, " R9 lock read"}, v, {15'd0, lk, k});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog all-R actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_cfg = DEF[18:0];

        // R1 reset state
        check_lock("R1 reset", 1'b1, 16'h0000);
        check_cfg("R1 reset", exp_cfg);

        // R4 locked writes ignored
        for (int i = 0; i < 32; i++) begin
            wr(2'd1, 32'h9E37_79B9 * (i + 1));
            check_cfg("R4 locked write", exp_cfg);
        end

        // R6 near-miss keys all keep lock; oscillator write stays blocked
        for (int b = 0; b < 16; b++) begin
            wr(2'd0, {16'h0, KEY ^ (16'h1 << b)});
            check_lock("R6 near key", 1'b1, KEY ^ (16'h1 << b));
            wr(2'd1, 32'h0007_FFFF ^ b);
            check_cfg("R4 after near key", exp_cfg);
        end

        // R6 upper bits of lock write not compared; R2 readback of low half
        wr(2'd0, {16'hFFFF, KEY});
        check_lock("R2 R6 key with high bits", 1'b0, KEY);

        // R3 R5 R7 sweep of every VCO divider value while unlocked
        for (int i = 0; i < 512; i++) begin
            logic [31:0] d;
            d = ((i * 32'h1357) << 19) | (((i % 8) & 7) << 16) | (((i * 37) & 127) << 9) | i;
            wr(2'd1, d);
            exp_cfg = d[18:0];
            check_cfg("R3 R7 unlocked sweep", exp_cfg);
        end
        check_lock("R7 still unlocked", 1'b0, KEY);

        // R8 unmapped addresses
        for (int a = 2; a < 4; a++) begin
            wr(2'(a), 32'hFFFF_FFFF);
            rd(2'(a), v);
            check("R8 unmapped read", v, 32'h0);
            check_lock("R8 lock untouched", 1'b0, KEY);
            check_cfg("R8 osc untouched", exp_cfg);
        end

        // R2 relock with zero, then locked write ignored
        wr(2'd0, 32'h0);
        check_lock("R2 relock zero", 1'b1, 16'h0000);
        wr(2'd1, 32'h0001_2345);
        check_cfg("R4 after relock", exp_cfg);

        // R6 relock with non-zero, non-key value
        wr(2'd0, {16'h0, KEY});
        check_lock("R2 unlock", 1'b0, KEY);
        wr(2'd0, 32'h0000_1234);
        check_lock("R6 relock nonzero", 1'b1, 16'h1234);

        // R1 reset in the middle of an unlocked session
        wr(2'd0, {16'h0, KEY});
        wr(2'd1, 32'h0005_5555);
        check_cfg("R3 before reset", 19'h5_5555);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_cfg = DEF[18:0];
        check_lock("R1 second reset", 1'b1, 16'h0000);
        check_cfg("R1 second reset", exp_cfg);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule